// File: doc/BRIEF.md
# Two-Level Operand Stack Cache

This block stores the operand stack of a stack-machine execution stage. The two topmost entries sit in registers, `tos_a` (top) and `nos_b` (next), so an execute stage can read both at once. All deeper entries live in a dual-port on-chip RAM addressed by a stack pointer `sp`, which always holds the RAM address of the third entry. The pipeline never sees RAM read latency. The RAM output always holds the word at `sp`, because the read address is set to the next cycle's pointer. A pop can therefore refill `nos_b` at once, with no bypass network.

Each cycle the execute stage gives one operation code, plus a data word (a pushed value or an ALU result) and a slot address for local-variable loads and stores. The same RAM holds local variables at absolute slot addresses. The control path is a two-state machine. `ST_RUN` is the normal single-cycle state. `ST_LOAD` is the second cycle of a slot load. The machine moves from `ST_RUN` to `ST_LOAD` when a load is accepted, and always returns from `ST_LOAD` to `ST_RUN` on the next cycle. Overflow and underflow of the total entry count set sticky flags. The offending operation is dropped.

Top module: `opstack_cache`

## Requirements
- R1: After reset, `sp` is all ones, `tos_a` and `nos_b` are zero, both error flags are low and `ready` is high.
- R2: Push (op 1) makes `din` the new top, moves the old top to `nos_b`, writes the old `nos_b` to RAM at `sp`+1 and increments `sp`.
- R3: Pop (op 2) moves `nos_b` to the top, refills `nos_b` with the RAM word at `sp` and decrements `sp`.
- R4: Binary operation (op 3) removes two entries and pushes `din` as the result: the top becomes `din`, `nos_b` takes the RAM word at `sp`, and `sp` decrements.
- R5: Load (op 4) takes two cycles. In the first cycle the machine enters `ST_LOAD` and nothing visible changes except that `ready` goes low. In the second cycle the op input is ignored, and the RAM word at `slot` is pushed as the new top exactly as in R2.
- R6: Store (op 5) writes the top to RAM at `slot` and pops one entry as in R3, all in one cycle.
- R7: Op 0 and the unused codes 6 and 7 change nothing.
- R8: With 2^SP_W+2 entries held, a push or a load sets `ovf_err`, is dropped and leaves the stack unchanged. The flag stays set until reset.
- R9: A pop or a store with no entries, or a binary operation with fewer than two entries, sets `unf_err` and is dropped. The flag stays set until reset.
- R10: After the stack is filled to capacity through the RAM, popping returns every entry in reverse order.
- R11: Push, pop, binary operation and store can be issued on consecutive cycles with `ready` staying high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Operation code (0 none, 1 push, 2 pop, 3 binary op, 4 load, 5 store) |
| din | input | DATA_W | Pushed value or ALU result |
| slot | input | SP_W | RAM address for load and store |
| ready | output | 1 | High when a new operation is accepted |
| tos_a | output | DATA_W | Top of stack |
| nos_b | output | DATA_W | Second stack entry |
| sp | output | SP_W | RAM address of the third entry |
| ovf_err | output | 1 | Sticky overflow flag |
| unf_err | output | 1 | Sticky underflow flag |

## Verification
The assertions assume that the op input is held at zero during reset. They also assume that a store never targets a RAM word still holding a live spilled entry, so that a slot store cannot disturb the prefetched word. The stimulus stores and loads only slots above the live region, and it fills the stack past those slots only after it has finished with them. The bench checks `nos_b` only when at least two entries exist and `tos_a` only when one exists, because their contents below that depth are undefined.

// File: rtl/opstack_pkg.sv
package opstack_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_PUSH  = 3'd1,
        OP_POP   = 3'd2,
        OP_BIN   = 3'd3,
        OP_LOAD  = 3'd4,
        OP_STORE = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_PUSH,
        ACT_POP,
        ACT_BIN,
        ACT_STORE,
        ACT_LDADDR,
        ACT_LDPUSH
    } act_e;

    typedef enum logic {
        ST_RUN,
        ST_LOAD
    } state_e;
endpackage

// File: rtl/opstack_ram.sv
module opstack_ram #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read; a same-cycle write to the read address returns the new word.
    always_ff @(posedge clk) begin
        if (we && (waddr == raddr)) begin
            rdata <= wdata;
        end else begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/opstack_ctrl.sv
module opstack_ctrl
    import opstack_pkg::*;
#(
    parameter int SP_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] op,
    output act_e       act,
    output logic       ready,
    output logic       ovf_err,
    output logic       unf_err
);
    localparam int CAP     = (1 << SP_W) + 2;
    localparam int DEPTH_W = $clog2(CAP + 1);

    state_e             state_q, state_d;
    logic [DEPTH_W-1:0] depth_q;
    logic               full, ovf_hit, unf_hit;

    assign full = (depth_q == DEPTH_W'(CAP));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        act     = ACT_NONE;
        ovf_hit = 1'b0;
        unf_hit = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                case (op)
                    OP_PUSH:  if (full) ovf_hit = 1'b1; else act = ACT_PUSH;
                    OP_POP:   if (depth_q == '0) unf_hit = 1'b1; else act = ACT_POP;
                    OP_BIN:   if (depth_q < DEPTH_W'(2)) unf_hit = 1'b1; else act = ACT_BIN;
                    OP_STORE: if (depth_q == '0) unf_hit = 1'b1; else act = ACT_STORE;
                    OP_LOAD: begin
                        if (full) begin
                            ovf_hit = 1'b1;
                        end else begin
                            act     = ACT_LDADDR;
                            state_d = ST_LOAD;
                        end
                    end
                    default: act = ACT_NONE;
                endcase
            end
            ST_LOAD: begin
                act     = ACT_LDPUSH;
                state_d = ST_RUN;
            end
        endcase
    end

    assign ready = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
            ovf_err <= 1'b0;
            unf_err <= 1'b0;
        end else begin
            if (ovf_hit) ovf_err <= 1'b1;
            if (unf_hit) unf_err <= 1'b1;
            unique case (act)
                ACT_PUSH, ACT_LDPUSH:       depth_q <= depth_q + 1'b1;
                ACT_POP, ACT_BIN, ACT_STORE: depth_q <= depth_q - 1'b1;
                default:                    depth_q <= depth_q;
            endcase
        end
    end

    assert_load_returns_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> (state_q == ST_RUN));
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= DEPTH_W'(CAP));
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);
    assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unf_err |=> unf_err);
endmodule

// File: rtl/opstack_cache.sv
module opstack_cache
    import opstack_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] din,
    input  logic [SP_W-1:0]   slot,
    output logic              ready,
    output logic [DATA_W-1:0] tos_a,
    output logic [DATA_W-1:0] nos_b,
    output logic [SP_W-1:0]   sp,
    output logic              ovf_err,
    output logic              unf_err
);
    act_e              act;
    logic [SP_W-1:0]   sp_q, sp_up, sp_dn;
    logic [SP_W-1:0]   raddr, waddr;
    logic [DATA_W-1:0] a_q, b_q, wdata, rdata;
    logic              we;

    opstack_ctrl #(.SP_W(SP_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .op(op), .act(act),
        .ready(ready), .ovf_err(ovf_err), .unf_err(unf_err)
    );

    opstack_ram #(.DATA_W(DATA_W), .ADDR_W(SP_W)) u_ram (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata)
    );

    assign sp_up = sp_q + 1'b1;
    assign sp_dn = sp_q - 1'b1;

    // Read address is next cycle's pointer so rdata always holds RAM[sp].
    always_comb begin
        raddr = sp_q;
        we    = 1'b0;
        waddr = sp_up;
        wdata = b_q;
        unique case (act)
            ACT_PUSH, ACT_LDPUSH: begin
                raddr = sp_up;
                we    = 1'b1;
            end
            ACT_POP, ACT_BIN: raddr = sp_dn;
            ACT_STORE: begin
                raddr = sp_dn;
                we    = 1'b1;
                waddr = slot;
                wdata = a_q;
            end
            ACT_LDADDR: raddr = slot;
            default:    raddr = sp_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            sp_q <= '1;
        end else begin
            unique case (act)
                ACT_PUSH: begin
                    a_q  <= din;
                    b_q  <= a_q;
                    sp_q <= sp_up;
                end
                ACT_LDPUSH: begin
                    a_q  <= rdata;
                    b_q  <= a_q;
                    sp_q <= sp_up;
                end
                ACT_POP, ACT_STORE: begin
                    a_q  <= b_q;
                    b_q  <= rdata;
                    sp_q <= sp_dn;
                end
                ACT_BIN: begin
                    a_q  <= din;
                    b_q  <= rdata;
                    sp_q <= sp_dn;
                end
                default: begin
                    a_q  <= a_q;
                    b_q  <= b_q;
                    sp_q <= sp_q;
                end
            endcase
        end
    end

    assign tos_a = a_q;
    assign nos_b = b_q;
    assign sp    = sp_q;

    assert_push_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_PUSH) |=> (tos_a == $past(din) && nos_b == $past(tos_a)));
    assert_pop_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_POP) |=> (tos_a == $past(nos_b) && sp == $past(sp) - 1'b1));
    assert_bin_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_BIN) |=> (tos_a == $past(din)));
    assert_load_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_LDPUSH) |=> (nos_b == $past(tos_a) && sp == $past(sp) + 1'b1));
    assert_load_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_LDADDR) |=> ($stable(tos_a) && $stable(sp) && !ready));
endmodule

// File: tb/test_opstack_cache.sv
module test_opstack_cache;
    localparam int DW  = 32;
    localparam int SW  = 4;
    localparam int CAP = (1 << SW) + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op = 3'd0;
    logic [DW-1:0] din = '0;
    logic [SW-1:0] slot = '0;
    logic          ready, ovf_err, unf_err;
    logic [DW-1:0] tos_a, nos_b;
    logic [SW-1:0] sp;

    int errors = 0;
    int checks = 0;

    // Requirement-level model
    logic [DW-1:0] stk [CAP];
    logic [DW-1:0] mram [1 << SW];
    int            md;
    logic          movf, munf, mbusy;
    logic [DW-1:0] mload;

    always #5 clk = ~clk;

    opstack_cache #(.DATA_W(DW), .SP_W(SW)) i_opstack_cache (
        .clk(clk), .rst_n(rst_n), .op(op), .din(din), .slot(slot),
        .ready(ready), .tos_a(tos_a), .nos_b(nos_b), .sp(sp),
        .ovf_err(ovf_err), .unf_err(unf_err)
    );

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [SW-1:0] msp;
        msp = SW'(md - 1);
        chk({tag, " ready"}, DW'(ready), DW'(!mbusy));
        chk({tag, " sp"}, DW'(sp), DW'(msp));
        chk({tag, " ovf"}, DW'(ovf_err), DW'(movf));
        chk({tag, " unf"}, DW'(unf_err), DW'(munf));
        if (md >= 1) chk({tag, " tos_a"}, tos_a, stk[md-1]);
        if (md >= 2) chk({tag, " nos_b"}, nos_b, stk[md-2]);
    endtask

    task automatic model(input logic [2:0] o, input logic [DW-1:0] d, input logic [SW-1:0] s);
        if (mbusy) begin
            stk[md] = mload;
            md++;
            mbusy = 1'b0;
            return;
        end
        case (o)
            3'd1: if (md == CAP) movf = 1'b1; else begin stk[md] = d; md++; end
            3'd2: if (md < 1) munf = 1'b1; else md--;
            3'd3: if (md < 2) munf = 1'b1; else begin md--; stk[md-1] = d; end
            3'd4: if (md == CAP) movf = 1'b1; else begin mbusy = 1'b1; mload = mram[s]; end
            3'd5: if (md < 1) munf = 1'b1; else begin mram[s] = stk[md-1]; md--; end
            default: ;
        endcase
    endtask

    task automatic issue(input logic [2:0] o, input logic [DW-1:0] d, input logic [SW-1:0] s);
        @(negedge clk);
        op = o; din = d; slot = s;
        @(posedge clk);
        #1;
        op = 3'd0;
        model(o, d, s);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op = 3'd0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        md = 0; movf = 1'b0; munf = 1'b0; mbusy = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check_all("R1 reset");
        chk("R1 tos_a zero", tos_a, '0);
        chk("R1 nos_b zero", nos_b, '0);
    endtask

    task automatic t_push_pop();
        do_reset();
        for (int i = 0; i < 5; i++) begin
            issue(3'd1, 32'hA000_0000 + DW'(i), '0);
            check_all("R2 push");
        end
        for (int i = 0; i < 3; i++) begin
            issue(3'd2, '0, '0);
            check_all("R3 pop");
        end
    endtask

    task automatic t_binop();
        do_reset();
        issue(3'd1, 32'h11, '0);
        issue(3'd1, 32'h22, '0);
        issue(3'd1, 32'h33, '0);
        issue(3'd1, 32'h44, '0);
        issue(3'd3, 32'h77, '0);
        check_all("R4 binop deep");
        issue(3'd3, 32'h99, '0);
        check_all("R4 binop refill");
    endtask

    task automatic t_store_load();
        do_reset();
        issue(3'd1, 32'hC0DE_0001, '0);
        issue(3'd1, 32'hC0DE_0002, '0);
        issue(3'd1, 32'hC0DE_0003, '0);
        issue(3'd5, '0, SW'(12));
        check_all("R6 store pops");
        issue(3'd5, '0, SW'(13));
        check_all("R6 store second");
        issue(3'd4, '0, SW'(12));
        check_all("R5 load first cycle busy");
        issue(3'd1, 32'hDEAD_BEEF, '0);
        check_all("R5 load pushes slot, op ignored");
        chk("R5 loaded value", tos_a, 32'hC0DE_0003);
        issue(3'd4, '0, SW'(13));
        issue(3'd2, '0, '0);
        check_all("R5 second load");
        chk("R6 stored then loaded", tos_a, 32'hC0DE_0002);
    endtask

    task automatic t_reserved();
        do_reset();
        issue(3'd1, 32'h5, '0);
        issue(3'd1, 32'h6, '0);
        issue(3'd0, 32'hFF, '0);
        check_all("R7 nop");
        issue(3'd6, 32'hFF, '0);
        check_all("R7 code 6");
        issue(3'd7, 32'hFF, '0);
        check_all("R7 code 7");
    endtask

    task automatic t_fill_drain();
        do_reset();
        for (int i = 0; i < CAP; i++) issue(3'd1, 32'hF000_0000 + DW'(i), '0);
        check_all("R10 full");
        issue(3'd1, 32'h0BAD_0BAD, '0);
        check_all("R8 push overflow");
        issue(3'd4, '0, '0);
        check_all("R8 load overflow");
        for (int i = CAP - 1; i >= 0; i--) begin
            if (md >= 1) chk("R10 lifo", tos_a, 32'hF000_0000 + DW'(i));
            issue(3'd2, '0, '0);
        end
        check_all("R10 drained");
        chk("R8 ovf sticky", DW'(ovf_err), 32'd1);
    endtask

    task automatic t_underflow();
        do_reset();
        issue(3'd2, '0, '0);
        check_all("R9 pop empty");
        do_reset();
        issue(3'd5, '0, SW'(9));
        check_all("R9 store empty");
        do_reset();
        issue(3'd1, 32'h42, '0);
        issue(3'd3, 32'h1, '0);
        check_all("R9 binop one entry");
        chk("R9 top kept", tos_a, 32'h42);
        issue(3'd1, 32'h43, '0);
        check_all("R9 unf sticky");
    endtask

    task automatic t_stream();
        do_reset();
        issue(3'd1, 32'h1, '0); check_all("R11 push");
        issue(3'd1, 32'h2, '0); check_all("R11 push");
        issue(3'd1, 32'h3, '0); check_all("R11 push");
        issue(3'd3, 32'h5, '0); check_all("R11 binop");
        issue(3'd5, '0, SW'(14)); check_all("R11 store");
        issue(3'd1, 32'h9, '0); check_all("R11 push");
        issue(3'd2, '0, '0);    check_all("R11 pop");
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        md = 0; movf = 1'b0; munf = 1'b0; mbusy = 1'b0; mload = '0;
        t_reset();
        t_push_pop();
        t_binop();
        t_store_load();
        t_reserved();
        t_fill_drain();
        t_underflow();
        t_stream();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule